// File: doc/BRIEF.md
# Real-Time Clock Index/Data Register File

This block is the register side of a battery-backed real-time clock. It holds 96 byte registers and is reached through a byte-wide bus with two ports. Port 0 latches an index, and port 1 reads or writes the register that index selects. The registers hold packed-BCD time-of-day fields, two writable control registers, two read-only status registers and a bank of general configuration bytes. The configuration bytes include the memory-size and processor-count fields that firmware reads at boot.

A clock source outside the block presents the current time in binary and pulses `time_load`. The block converts the time to BCD and writes all time fields and the century byte in one cycle. During that cycle it drops the time-valid flag and raises it again on the next cycle. An external periodic timer pulses `per_tick` to set the periodic flag in status register C, and a read of C clears that flag. Writes to control registers A and B produce a one-cycle strobe so that the timer can reload its rate.

Top module: `rtc_cmos_regfile`

## Requirements
- R1: A read of port 0 returns the latched index, zero-extended to 8 bits. The index is 0x00 after reset.
- R2: A write to port 0 ignores bit 7 of the written byte before the index is decoded. For example, 0x8B selects 0x0B.
- R3: If the 7-bit index value is 0x60 or higher, the latched index becomes 0x0D (status register D).
- R4: A port-1 write to the time fields (0x00, 0x02, 0x04, 0x06, 0x07, 0x08, 0x09) or to the range 0x0E to 0x5F stores the byte unchanged.
- R5: A port-1 write to 0x01, 0x03, 0x05, 0x0C or 0x0D is discarded, and the register keeps its value.
- R6: A `per_tick` pulse sets bit 6 of register C (0x0C). A port-1 read of C returns the value held before the read edge and then clears bit 6. When a tick and a clearing read fall on the same edge, the tick wins.
- R7: A `time_load` pulse writes the following BCD bytes: seconds to 0x00, minutes to 0x02, hours to 0x04, weekday+1 to 0x06, day of month to 0x07, month+1 to 0x08, year mod 100 to 0x09 and year/100 to 0x32. On that same edge it clears bit 7 of 0x0D, and it sets that bit again on the first edge where `time_load` is low. The load overrides a port-1 write on the same edge.
- R8: After reset, register 0x0B holds 0x02 (the 24-hour bit). Bytes 0x34/0x35 hold MEM_LO_UNITS (low/high). Bytes 0x5B/0x5C/0x5D hold MEM_HI_UNITS (low/mid/high), and 0x5F holds CPU_COUNT. All other registers hold zero.
- R9: A port-1 write to 0x0A or 0x0B stores the whole byte. One cycle later it raises `ctl_a_stb` or `ctl_b_stb` respectively for exactly one cycle. `reg_a_q` and `reg_b_q` always show the stored values.
- R10: `bus_rdata` is registered. It is valid on the cycle after a read strobe and keeps its value when no read occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | 0 selects the index port, 1 selects the data port |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| per_tick | input | 1 | Periodic event from the external rate timer |
| time_load | input | 1 | Load the time inputs into the time fields |
| tl_sec | input | 6 | Seconds, 0-59 |
| tl_min | input | 6 | Minutes, 0-59 |
| tl_hour | input | 5 | Hours, 0-23 |
| tl_wday | input | 3 | Weekday, 0-6 |
| tl_mday | input | 5 | Day of month, 1-31 |
| tl_mon | input | 4 | Month, 0-11 |
| tl_year | input | 14 | Full year, below 10000 |
| reg_a_q | output | 8 | Stored control register A |
| reg_b_q | output | 8 | Stored control register B |
| ctl_a_stb | output | 1 | One-cycle pulse after a write to A |
| ctl_b_stb | output | 1 | One-cycle pulse after a write to B |
| pf_pending | output | 1 | Periodic flag, bit 6 of C |
| time_valid | output | 1 | Time-valid flag, bit 7 of D |

## Verification
The following properties are checked on every cycle:
- the latched index always stays inside the 96-byte space;
- both status registers are immune to port writes;
- the periodic flag sets on a tick and clears on a read of C;
- the valid flag drops on every load and returns after it;
- the control strobes follow only their own writes;
- the read data stays stable when no read occurs.

The bench's scenarios are needed for the value-level behaviour. This covers the reset contents, including the parameter-set configuration bytes, the index masking and the out-of-range fallback. It also covers the exact BCD conversion of a full timestamp, the load overriding a concurrent write, and the tick-versus-clear collision seen through the returned data.

// File: rtl/rtc_cmos_pkg.sv
// Package: layout constants, write classes and BCD helpers shared by the
// register-file modules. The byte layout is fixed because software decodes it.
package rtc_cmos_pkg;

    localparam int NREG  = 96;
    localparam int IDX_W = $clog2(NREG);

    localparam logic [IDX_W-1:0] IX_SEC   = 7'h00;
    localparam logic [IDX_W-1:0] IX_MIN   = 7'h02;
    localparam logic [IDX_W-1:0] IX_HOUR  = 7'h04;
    localparam logic [IDX_W-1:0] IX_DOW   = 7'h06;
    localparam logic [IDX_W-1:0] IX_DOM   = 7'h07;
    localparam logic [IDX_W-1:0] IX_MON   = 7'h08;
    localparam logic [IDX_W-1:0] IX_YEAR  = 7'h09;
    localparam logic [IDX_W-1:0] IX_CTLA  = 7'h0A;
    localparam logic [IDX_W-1:0] IX_CTLB  = 7'h0B;
    localparam logic [IDX_W-1:0] IX_STATC = 7'h0C;
    localparam logic [IDX_W-1:0] IX_STATD = 7'h0D;
    localparam logic [IDX_W-1:0] IX_NV0   = 7'h0E;
    localparam logic [IDX_W-1:0] IX_CENT  = 7'h32;
    localparam logic [IDX_W-1:0] IX_MLO   = 7'h34;
    localparam logic [IDX_W-1:0] IX_MHI   = 7'h35;
    localparam logic [IDX_W-1:0] IX_XLO   = 7'h5B;
    localparam logic [IDX_W-1:0] IX_XMID  = 7'h5C;
    localparam logic [IDX_W-1:0] IX_XHI   = 7'h5D;
    localparam logic [IDX_W-1:0] IX_CPUS  = 7'h5F;

    localparam int BIT_24H = 1;   // in control B
    localparam int BIT_PF  = 6;   // in status C
    localparam int BIT_VT  = 7;   // in status D

    typedef enum logic [1:0] {WK_STORE, WK_CTLA, WK_CTLB, WK_DROP} wkind_t;

    typedef struct packed {
        logic [7:0] sec;
        logic [7:0] min;
        logic [7:0] hour;
        logic [7:0] dow;
        logic [7:0] dom;
        logic [7:0] mon;
        logic [7:0] yr;
        logic [7:0] cent;
    } tod_bcd_t;

    // Classify a data-port write by target index.
    function automatic wkind_t wr_kind(logic [IDX_W-1:0] ix);
        if (ix == IX_CTLA)                                 return WK_CTLA;
        if (ix == IX_CTLB)                                 return WK_CTLB;
        if (ix >= IX_NV0)                                  return WK_STORE;
        if (ix == IX_SEC || ix == IX_MIN || ix == IX_HOUR) return WK_STORE;
        if (ix >= IX_DOW && ix <= IX_YEAR)                 return WK_STORE;
        return WK_DROP;
    endfunction

    // Two-digit binary to packed BCD; input assumed below 100.
    function automatic logic [7:0] to_bcd(logic [6:0] v);
        logic [6:0] tens;
        logic [6:0] ones;
        tens = v / 7'd10;
        ones = v % 7'd10;
        return {tens[3:0], ones[3:0]};
    endfunction

endpackage

// File: rtl/rtc_index_latch.sv
// Index latch: captures the port-0 write value, drops bit 7, and redirects any
// value outside the register space to status register D.
// Assumes at most one index write per cycle.
module rtc_index_latch
    import rtc_cmos_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             idx_wr,
    input  logic [7:0]       wdata,
    output logic [IDX_W-1:0] idx
);

    logic [6:0] masked;
    assign masked = wdata[6:0];

    // Latch the decoded index on a port-0 write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            idx <= '0;
        else if (idx_wr)
            idx <= (int'(masked) < NREG) ? masked[IDX_W-1:0] : IX_STATD;
    end

    a_r3_idx_in_space: assert property (@(posedge clk) disable iff (!rst_n)
        int'(idx) < NREG);

endmodule

// File: rtl/rtc_tod_loader.sv
// Time loader: converts the binary time inputs to packed BCD for a one-cycle
// load, and produces the pulse that restores the valid flag afterwards.
// Assumes the inputs are in range (year below 10000) while time_load is high.
module rtc_tod_loader
    import rtc_cmos_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        time_load,
    input  logic [5:0]  tl_sec,
    input  logic [5:0]  tl_min,
    input  logic [4:0]  tl_hour,
    input  logic [2:0]  tl_wday,
    input  logic [4:0]  tl_mday,
    input  logic [3:0]  tl_mon,
    input  logic [13:0] tl_year,
    output tod_bcd_t    tod,
    output logic        ld_we,
    output logic        vt_set
);

    logic        load_q;
    logic [13:0] yy;
    logic [13:0] cc;

    assign yy = tl_year % 14'd100;
    assign cc = tl_year / 14'd100;

    // Convert every field to BCD; weekday and month become 1-based.
    always_comb begin
        tod.sec  = to_bcd(7'(tl_sec));
        tod.min  = to_bcd(7'(tl_min));
        tod.hour = to_bcd(7'(tl_hour));
        tod.dow  = to_bcd(7'(tl_wday) + 7'd1);
        tod.dom  = to_bcd(7'(tl_mday));
        tod.mon  = to_bcd(7'(tl_mon) + 7'd1);
        tod.yr   = to_bcd(yy[6:0]);
        tod.cent = to_bcd(cc[6:0]);
    end

    // Remember the last load, so the valid flag returns after it ends.
    always_ff @(posedge clk) begin
        if (!rst_n) load_q <= 1'b0;
        else        load_q <= time_load;
    end

    assign ld_we  = time_load;
    assign vt_set = load_q && !time_load;

endmodule

// File: rtl/rtc_reg_store.sv
// Register store: the 96-byte array with the data-port write policy, status
// flag handling, time-load writes and the registered read path.
// Assumes the index is already in range.
module rtc_reg_store
    import rtc_cmos_pkg::*;
#(
    parameter logic [15:0] MEM_LO_UNITS = 16'h3F00,
    parameter logic [23:0] MEM_HI_UNITS = 24'h040000,
    parameter logic [7:0]  CPU_COUNT    = 8'h00
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] idx,
    input  logic             bus_sel,
    input  logic             bus_rd,
    input  logic             dat_wr,
    input  logic [7:0]       wdata,
    input  logic             per_tick,
    input  tod_bcd_t         tod,
    input  logic             ld_we,
    input  logic             vt_set,
    output logic [7:0]       rdata,
    output logic [7:0]       reg_a_q,
    output logic [7:0]       reg_b_q,
    output logic             ctl_a_stb,
    output logic             ctl_b_stb,
    output logic             pf_pending,
    output logic             time_valid
);

    logic [7:0] mem [NREG];
    wkind_t     kind;
    logic       rd_c;

    assign kind = wr_kind(idx);
    assign rd_c = bus_rd && bus_sel && (idx == IX_STATC);

    // Apply port writes, flag updates and time loads, in rising priority.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) mem[i] <= '0;
            mem[IX_CTLB] <= 8'(1 << BIT_24H);
            mem[IX_MLO]  <= MEM_LO_UNITS[7:0];
            mem[IX_MHI]  <= MEM_LO_UNITS[15:8];
            mem[IX_XLO]  <= MEM_HI_UNITS[7:0];
            mem[IX_XMID] <= MEM_HI_UNITS[15:8];
            mem[IX_XHI]  <= MEM_HI_UNITS[23:16];
            mem[IX_CPUS] <= CPU_COUNT;
            ctl_a_stb    <= 1'b0;
            ctl_b_stb    <= 1'b0;
        end else begin
            ctl_a_stb <= 1'b0;
            ctl_b_stb <= 1'b0;
            if (dat_wr) begin
                case (kind)
                    WK_STORE: mem[idx] <= wdata;
                    WK_CTLA:  begin mem[idx] <= wdata; ctl_a_stb <= 1'b1; end
                    WK_CTLB:  begin mem[idx] <= wdata; ctl_b_stb <= 1'b1; end
                    default:  ;
                endcase
            end
            if (rd_c)     mem[IX_STATC][BIT_PF] <= 1'b0;
            if (per_tick) mem[IX_STATC][BIT_PF] <= 1'b1;
            if (ld_we) begin
                mem[IX_SEC]          <= tod.sec;
                mem[IX_MIN]          <= tod.min;
                mem[IX_HOUR]         <= tod.hour;
                mem[IX_DOW]          <= tod.dow;
                mem[IX_DOM]          <= tod.dom;
                mem[IX_MON]          <= tod.mon;
                mem[IX_YEAR]         <= tod.yr;
                mem[IX_CENT]         <= tod.cent;
                mem[IX_STATD][BIT_VT] <= 1'b0;
            end else if (vt_set) begin
                mem[IX_STATD][BIT_VT] <= 1'b1;
            end
        end
    end

    // Register read data from either the index or the selected byte.
    always_ff @(posedge clk) begin
        if (!rst_n)      rdata <= '0;
        else if (bus_rd) rdata <= bus_sel ? mem[idx] : 8'(idx);
    end

    assign reg_a_q    = mem[IX_CTLA];
    assign reg_b_q    = mem[IX_CTLB];
    assign pf_pending = mem[IX_STATC][BIT_PF];
    assign time_valid = mem[IX_STATD][BIT_VT];

    // R5: status registers ignore port writes
    a_r5_stat_c_ro: assert property (@(posedge clk) disable iff (!rst_n)
        (dat_wr && idx == IX_STATC && !per_tick && !bus_rd) |=> $stable(mem[IX_STATC]));
    a_r5_stat_d_ro: assert property (@(posedge clk) disable iff (!rst_n)
        (dat_wr && idx == IX_STATD && !ld_we && !vt_set) |=> $stable(mem[IX_STATD]));
    // R6: flag set by tick, cleared by read of C
    a_r6_tick_sets: assert property (@(posedge clk) disable iff (!rst_n)
        per_tick |=> pf_pending);
    a_r6_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_c && !per_tick) |=> !pf_pending);
    // R9: strobes follow their own writes only
    a_r9_stb_excl: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ctl_a_stb, ctl_b_stb}));
    a_r9_a_stb: assert property (@(posedge clk) disable iff (!rst_n)
        (dat_wr && idx == IX_CTLA) |=> ctl_a_stb);
    // R10: read data holds without a read
    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> $stable(rdata));

endmodule

// File: rtl/rtc_cmos_regfile.sv
// Top: two-port RTC index/data register file. It splits the bus strobes
// between the index latch and the register store, and feeds time loads
// through the BCD loader. Assumes single-cycle strobes from a synchronous master.
module rtc_cmos_regfile
    import rtc_cmos_pkg::*;
#(
    parameter logic [15:0] MEM_LO_UNITS = 16'h3F00,
    parameter logic [23:0] MEM_HI_UNITS = 24'h040000,
    parameter logic [7:0]  CPU_COUNT    = 8'h00
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_sel,
    input  logic        bus_rd,
    input  logic        bus_wr,
    input  logic [7:0]  bus_wdata,
    output logic [7:0]  bus_rdata,
    input  logic        per_tick,
    input  logic        time_load,
    input  logic [5:0]  tl_sec,
    input  logic [5:0]  tl_min,
    input  logic [4:0]  tl_hour,
    input  logic [2:0]  tl_wday,
    input  logic [4:0]  tl_mday,
    input  logic [3:0]  tl_mon,
    input  logic [13:0] tl_year,
    output logic [7:0]  reg_a_q,
    output logic [7:0]  reg_b_q,
    output logic        ctl_a_stb,
    output logic        ctl_b_stb,
    output logic        pf_pending,
    output logic        time_valid
);

    logic [IDX_W-1:0] idx;
    tod_bcd_t         tod;
    logic             ld_we;
    logic             vt_set;

    rtc_index_latch u_idx (
        .clk    (clk),
        .rst_n  (rst_n),
        .idx_wr (bus_wr && !bus_sel),
        .wdata  (bus_wdata),
        .idx    (idx)
    );

    rtc_tod_loader u_tod (
        .clk       (clk),
        .rst_n     (rst_n),
        .time_load (time_load),
        .tl_sec    (tl_sec),
        .tl_min    (tl_min),
        .tl_hour   (tl_hour),
        .tl_wday   (tl_wday),
        .tl_mday   (tl_mday),
        .tl_mon    (tl_mon),
        .tl_year   (tl_year),
        .tod       (tod),
        .ld_we     (ld_we),
        .vt_set    (vt_set)
    );

    rtc_reg_store #(
        .MEM_LO_UNITS (MEM_LO_UNITS),
        .MEM_HI_UNITS (MEM_HI_UNITS),
        .CPU_COUNT    (CPU_COUNT)
    ) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .idx        (idx),
        .bus_sel    (bus_sel),
        .bus_rd     (bus_rd),
        .dat_wr     (bus_wr && bus_sel),
        .wdata      (bus_wdata),
        .per_tick   (per_tick),
        .tod        (tod),
        .ld_we      (ld_we),
        .vt_set     (vt_set),
        .rdata      (bus_rdata),
        .reg_a_q    (reg_a_q),
        .reg_b_q    (reg_b_q),
        .ctl_a_stb  (ctl_a_stb),
        .ctl_b_stb  (ctl_b_stb),
        .pf_pending (pf_pending),
        .time_valid (time_valid)
    );

    // R7: valid flag drops on a load and returns once the load ends
    a_r7_vt_drop: assert property (@(posedge clk) disable iff (!rst_n)
        time_load |=> !time_valid);
    a_r7_vt_back: assert property (@(posedge clk) disable iff (!rst_n)
        vt_set |=> time_valid);

endmodule

// File: tb/rtc_cmos_regfile_tb.sv
`timescale 1ns/1ps
module rtc_cmos_regfile_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_rd = 1'b0, bus_wr = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic        per_tick = 1'b0, time_load = 1'b0;
    logic [5:0]  tl_sec = '0, tl_min = '0;
    logic [4:0]  tl_hour = '0, tl_mday = '0;
    logic [2:0]  tl_wday = '0;
    logic [3:0]  tl_mon = '0;
    logic [13:0] tl_year = '0;
    logic [7:0]  reg_a_q, reg_b_q;
    logic        ctl_a_stb, ctl_b_stb, pf_pending, time_valid;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    logic [7:0] q_exp [$];
    string      q_tag [$];
    logic       rd_seen = 1'b0;

    always #4 clk = ~clk;

    rtc_cmos_regfile u_dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_rd(bus_rd),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .per_tick(per_tick), .time_load(time_load),
        .tl_sec(tl_sec), .tl_min(tl_min), .tl_hour(tl_hour), .tl_wday(tl_wday),
        .tl_mday(tl_mday), .tl_mon(tl_mon), .tl_year(tl_year),
        .reg_a_q(reg_a_q), .reg_b_q(reg_b_q), .ctl_a_stb(ctl_a_stb),
        .ctl_b_stb(ctl_b_stb), .pf_pending(pf_pending), .time_valid(time_valid)
    );

    task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    // Monitor: a read issued before the last rising edge is due now.
    always @(posedge clk) rd_seen <= bus_rd;
    always @(negedge clk) begin
        if (rd_seen) begin
            if (q_exp.size() == 0) begin
                checks++; fails++;
                $display("FAIL R10 unexpected read actual=%02h expected=none", bus_rdata);
            end else begin
                check(q_tag.pop_front(), bus_rdata, q_exp.pop_front());
            end
        end
    end

    task automatic bus_write(logic sel, logic [7:0] d);
        bus_sel = sel; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(logic sel, logic [7:0] exp, string tag);
        bus_sel = sel; bus_rd = 1'b1;
        q_exp.push_back(exp); q_tag.push_back(tag);
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic reg_read(logic [7:0] ix, logic [7:0] exp, string tag);
        bus_write(1'b0, ix);
        bus_read(1'b1, exp, tag);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R8 reset state
        check("R8 reg_b_q", reg_b_q, 8'h02);
        check("R8 time_valid", {7'd0, time_valid}, 8'h00);
        check("R8 pf_pending", {7'd0, pf_pending}, 8'h00);
        bus_read(1'b0, 8'h00, "R1 reset index");
        bus_read(1'b1, 8'h00, "R8 sec zero");
        reg_read(8'h0B, 8'h02, "R8 ctl B");
        reg_read(8'h34, 8'h00, "R8 mem lo");
        reg_read(8'h35, 8'h3F, "R8 mem hi");
        reg_read(8'h5D, 8'h04, "R8 ext hi");
        reg_read(8'h0D, 8'h00, "R8 stat D");

        // R2 and R3 index decode
        bus_write(1'b0, 8'h8B);
        bus_read(1'b0, 8'h0B, "R2 bit7 dropped");
        bus_write(1'b0, 8'hDF);
        bus_read(1'b0, 8'h5F, "R2 masked top");
        bus_write(1'b0, 8'h60);
        bus_read(1'b0, 8'h0D, "R3 0x60 to D");
        bus_write(1'b0, 8'hFF);
        bus_read(1'b0, 8'h0D, "R3 0x7F to D");

        // R4 plain stores
        bus_write(1'b0, 8'h20); bus_write(1'b1, 8'hA5);
        reg_read(8'h20, 8'hA5, "R4 nvram");
        bus_write(1'b0, 8'h00); bus_write(1'b1, 8'h37);
        reg_read(8'h00, 8'h37, "R4 seconds");
        bus_write(1'b0, 8'h09); bus_write(1'b1, 8'h99);
        reg_read(8'h09, 8'h99, "R4 year");

        // R5 discarded writes
        bus_write(1'b0, 8'h01); bus_write(1'b1, 8'h55);
        reg_read(8'h01, 8'h00, "R5 alarm");
        bus_write(1'b0, 8'h0C); bus_write(1'b1, 8'hFF);
        reg_read(8'h0C, 8'h00, "R5 stat C");
        bus_write(1'b0, 8'h0D); bus_write(1'b1, 8'hFF);
        reg_read(8'h0D, 8'h00, "R5 stat D");

        // R9 control writes and strobes
        bus_write(1'b0, 8'h0A);
        bus_write(1'b1, 8'h26);
        check("R9 a stb", {7'd0, ctl_a_stb}, 8'h01);
        check("R9 b quiet", {7'd0, ctl_b_stb}, 8'h00);
        check("R9 reg a", reg_a_q, 8'h26);
        @(negedge clk);
        check("R9 a stb one cycle", {7'd0, ctl_a_stb}, 8'h00);
        bus_write(1'b0, 8'h0B);
        bus_write(1'b1, 8'h42);
        check("R9 b stb", {7'd0, ctl_b_stb}, 8'h01);
        check("R9 reg b", reg_b_q, 8'h42);

        // R6 periodic flag
        bus_write(1'b0, 8'h0C);
        per_tick = 1'b1; @(negedge clk); per_tick = 1'b0;
        check("R6 pf set", {7'd0, pf_pending}, 8'h01);
        bus_read(1'b1, 8'h40, "R6 read C");
        check("R6 pf cleared", {7'd0, pf_pending}, 8'h00);
        bus_read(1'b1, 8'h00, "R6 read C again");
        per_tick = 1'b1;
        bus_read(1'b1, 8'h00, "R6 collision old value");
        per_tick = 1'b0;
        check("R6 tick wins", {7'd0, pf_pending}, 8'h01);
        bus_read(1'b1, 8'h40, "R6 flag kept");

        // R7 time load: 2024-02-29 Thu 23:59:58
        tl_sec = 6'd58; tl_min = 6'd59; tl_hour = 5'd23; tl_wday = 3'd4;
        tl_mday = 5'd29; tl_mon = 4'd1; tl_year = 14'd2024;
        time_load = 1'b1; @(negedge clk); time_load = 1'b0;
        check("R7 valid dropped", {7'd0, time_valid}, 8'h00);
        @(negedge clk);
        check("R7 valid back", {7'd0, time_valid}, 8'h01);
        reg_read(8'h00, 8'h58, "R7 sec");
        reg_read(8'h02, 8'h59, "R7 min");
        reg_read(8'h04, 8'h23, "R7 hour");
        reg_read(8'h06, 8'h05, "R7 dow");
        reg_read(8'h07, 8'h29, "R7 dom");
        reg_read(8'h08, 8'h02, "R7 month");
        reg_read(8'h09, 8'h24, "R7 year");
        reg_read(8'h32, 8'h20, "R7 century");
        reg_read(8'h0D, 8'h80, "R7 stat D valid");

        // R7 load overrides a concurrent seconds write
        bus_write(1'b0, 8'h00);
        tl_sec = 6'd7; tl_year = 14'd1999;
        time_load = 1'b1;
        bus_write(1'b1, 8'h33);
        time_load = 1'b0;
        bus_read(1'b1, 8'h07, "R7 load wins");
        reg_read(8'h09, 8'h99, "R7 year 1999");
        reg_read(8'h32, 8'h19, "R7 century 19");

        // R10 read data holds
        check("R10 hold", bus_rdata, 8'h19);
        repeat (2) @(negedge clk);
        check("R10 hold later", bus_rdata, 8'h19);

        repeat (2) @(negedge clk);
        if (q_exp.size() != 0) begin
            checks++; fails++;
            $display("FAIL R10 pending reads actual=%0d expected=0", q_exp.size());
        end
        finish_run();
    end

endmodule